// File: doc/BRIEF.md
# Bit-Stripping Serial Frame Receiver

This block sits behind a bit sampler on a synchronous serial link. Each cycle with the valid strobe high it takes one line bit. It finds the flags that bound frames and removes the zeros that the sender inserted after runs of ones. It also catches abort runs. Between flags it packs the remaining data bits into bytes and presents each byte with a one-cycle strobe. Start-of-frame, end-of-frame, abort and residue indications come out as single-cycle pulses aligned with the byte stream.

All three line checks run in one pass over a counter of consecutive ones. The bits of a run are held back until the run ends, because only then is it known whether they are data, a stuffed gap, part of a flag or part of an abort. As a result the bits of a closing flag never reach the byte assembler. Clock recovery, line decoding, CRC, address and control-field handling stay outside.

Top module: `destuff_rx`

## Requirements
- R1: While rst_ni is low, byte_valid_o, sof_o, eof_o, abort_o and residue_err_o are 0 and byte_o is 8'h00.
- R2: A flag is a 0, then exactly six 1s, then a 0, in line order. No byte is output before the first flag or at any time while no frame is open.
- R3: Inside a frame, a 0 that arrives directly after five consecutive 1s is discarded and does not count as a data bit.
- R4: A run of seven or more consecutive 1s is an abort. If a frame is open, abort_o pulses once, in the cycle after the seventh 1, and the frame closes with no eof_o. No byte follows until the next flag. With no frame open there is no pulse.
- R5: Data bits are packed least significant bit first: the first data bit after a flag lands in byte_o[0]. byte_valid_o pulses in the cycle after the strobe on which the run holding the eighth bit is resolved.
- R6: A flag that arrives while a frame is open and at least one data bit has arrived since the opening flag pulses eof_o once, in the cycle after the flag's last 0. The same flag opens the next frame.
- R7: Flags with no data bit between them produce no eof_o and no sof_o.
- R8: residue_err_o pulses together with eof_o when the number of data bits in the frame is not a multiple of 8, and never at any other time.
- R9: sof_o pulses together with byte_valid_o for the first byte of each frame only.
- R10: A cycle with bit_valid_i low leaves the receiver state unchanged and produces no byte, eof or abort pulse in the next cycle, whatever bit_i holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Sampled line bit |
| bit_valid_i | input | 1 | bit_i holds a new bit this cycle |
| byte_o | output | 8 | Last assembled byte, LSB first on the line |
| byte_valid_o | output | 1 | byte_o is new this cycle |
| sof_o | output | 1 | First byte of a frame |
| eof_o | output | 1 | Frame closed by a flag |
| abort_o | output | 1 | Open frame dropped by an abort run |
| residue_err_o | output | 1 | Closed frame ended on a partial byte |

## Verification
Every cycle, the assertions check how the pulses relate to each other: sof only with a byte, residue only with eof, eof and abort never together, and no byte right after an abort. They also check that a cycle without a strobe leaves all event outputs quiet in the next cycle. Payload correctness cannot be checked that way. That covers stripping of stuffed zeros, LSB-first packing, frames with shared or repeated flags, byte counts that are not whole, and data ignored between an abort and the next flag. These can only be shown by the bench. It builds frames from random payloads with a stuffing sender and compares what comes out against what was sent.

// File: rtl/destuff_rx_pkg.sv
package destuff_rx_pkg;
  typedef struct packed {
    logic flag;
    logic abort;
  } line_evt_t;
endpackage

// File: rtl/destuff_line_scan.sv
module destuff_line_scan
  import destuff_rx_pkg::*;
#(
  parameter int unsigned STUFF_RUN = 5,
  localparam int unsigned SEG_W    = STUFF_RUN + 1,
  localparam int unsigned SEGN_W   = $clog2(SEG_W + 1),
  localparam int unsigned RUN_W    = $clog2(STUFF_RUN + 3)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_i,
  input  logic              valid_i,
  output logic              seg_push_o,
  output logic [SEGN_W-1:0] seg_n_o,
  output logic [SEG_W-1:0]  seg_bits_o,
  output line_evt_t         evt_o
);
  localparam int unsigned FLAG_RUN  = STUFF_RUN + 1;
  localparam int unsigned ABORT_RUN = STUFF_RUN + 2;

  logic [RUN_W-1:0] ones_q;
  logic             zlead_q;  // current run was opened by a zero
  logic             pend_q;   // that zero is data still awaiting the run's outcome
  logic [SEG_W-1:0] ones_vec;

  always_comb begin
    for (int i = 0; i < int'(SEG_W); i++) ones_vec[i] = (i < int'(ones_q));
  end

  always_comb begin
    seg_push_o  = 1'b0;
    seg_n_o     = '0;
    seg_bits_o  = '0;
    evt_o       = '0;
    if (valid_i) begin
      if (bit_i) begin
        evt_o.abort = (ones_q == RUN_W'(FLAG_RUN));
      end else if (ones_q == RUN_W'(FLAG_RUN)) begin
        evt_o.flag = zlead_q;
      end else if (ones_q <= RUN_W'(STUFF_RUN)) begin
        seg_n_o    = SEGN_W'(pend_q) + SEGN_W'(ones_q);
        seg_bits_o = pend_q ? {ones_vec[SEG_W-2:0], 1'b0} : ones_vec;
        seg_push_o = (seg_n_o != '0);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ones_q  <= '0;
      zlead_q <= 1'b0;
      pend_q  <= 1'b0;
    end else if (valid_i) begin
      if (bit_i) begin
        if (ones_q != RUN_W'(ABORT_RUN)) ones_q <= ones_q + 1'b1;
      end else begin
        ones_q  <= '0;
        zlead_q <= 1'b1;
        pend_q  <= (ones_q < RUN_W'(STUFF_RUN));
      end
    end
  end

  // R3: a segment never carries more than one zero plus a run of at most STUFF_RUN ones
  p_seg_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_push_o |-> ($countones(seg_bits_o) <= STUFF_RUN));
endmodule

// File: rtl/destuff_byte_pack.sv
module destuff_byte_pack #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned SEG_W  = 6,
  localparam int unsigned SEGN_W = $clog2(SEG_W + 1),
  localparam int unsigned CNT_W  = $clog2(BYTE_W),
  localparam int unsigned ACC_W  = BYTE_W + SEG_W,
  localparam int unsigned SUM_W  = $clog2(BYTE_W + SEG_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [SEGN_W-1:0] n_i,
  input  logic [SEG_W-1:0]  bits_i,
  input  logic              clear_i,
  output logic              fire_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_valid_o,
  output logic              any_o,
  output logic              partial_o
);
  logic [BYTE_W-1:0] acc_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              any_q;
  logic [ACC_W-1:0]  wide;
  logic [SUM_W-1:0]  sum;

  always_comb begin
    wide   = ACC_W'(acc_q) | (ACC_W'(bits_i) << cnt_q);
    sum    = SUM_W'(cnt_q) + SUM_W'(n_i);
    fire_o = push_i && (sum >= SUM_W'(BYTE_W));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q        <= '0;
      cnt_q        <= '0;
      any_q        <= 1'b0;
      byte_o       <= '0;
      byte_valid_o <= 1'b0;
    end else begin
      byte_valid_o <= fire_o;
      if (fire_o) byte_o <= wide[BYTE_W-1:0];
      if (clear_i) begin
        acc_q <= '0;
        cnt_q <= '0;
        any_q <= 1'b0;
      end else if (push_i) begin
        any_q <= 1'b1;
        if (fire_o) begin
          acc_q <= BYTE_W'(wide >> BYTE_W);
          cnt_q <= CNT_W'(sum - SUM_W'(BYTE_W));
        end else begin
          acc_q <= wide[BYTE_W-1:0];
          cnt_q <= CNT_W'(sum);
        end
      end
    end
  end

  assign any_o     = any_q;
  assign partial_o = (cnt_q != '0);

  // R5: a clear always restarts byte alignment at bit 0
  p_align_on_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !partial_o && !any_o);
endmodule

// File: rtl/destuff_frame_ctl.sv
module destuff_frame_ctl
  import destuff_rx_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  line_evt_t evt_i,
  input  logic      fire_i,
  input  logic      any_i,
  input  logic      partial_i,
  output logic      open_o,
  output logic      sof_o,
  output logic      eof_o,
  output logic      abort_o,
  output logic      residue_o
);
  logic open_q, first_q;
  logic close_ev;

  assign close_ev = evt_i.flag && open_q && any_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q    <= 1'b0;
      first_q   <= 1'b0;
      sof_o     <= 1'b0;
      eof_o     <= 1'b0;
      abort_o   <= 1'b0;
      residue_o <= 1'b0;
    end else begin
      sof_o     <= fire_i && first_q;
      eof_o     <= close_ev;
      residue_o <= close_ev && partial_i;
      abort_o   <= evt_i.abort && open_q;
      if (evt_i.flag)       open_q <= 1'b1;
      else if (evt_i.abort) open_q <= 1'b0;
      if (evt_i.flag)       first_q <= 1'b1;
      else if (fire_i)      first_q <= 1'b0;
    end
  end

  assign open_o = open_q;

  // R2: bytes are only assembled inside an open frame
  p_fire_in_frame_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |-> open_q);
endmodule

// File: rtl/destuff_rx.sv
module destuff_rx
  import destuff_rx_pkg::*;
#(
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned STUFF_RUN = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_i,
  input  logic              bit_valid_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_valid_o,
  output logic              sof_o,
  output logic              eof_o,
  output logic              abort_o,
  output logic              residue_err_o
);
  localparam int unsigned SEG_W  = STUFF_RUN + 1;
  localparam int unsigned SEGN_W = $clog2(SEG_W + 1);

  logic              seg_push;
  logic [SEGN_W-1:0] seg_n;
  logic [SEG_W-1:0]  seg_bits;
  line_evt_t         evt;
  logic              open, fire, any, partial;

  destuff_line_scan #(.STUFF_RUN(STUFF_RUN)) i_scan (
    .clk_i, .rst_ni, .bit_i, .valid_i(bit_valid_i),
    .seg_push_o(seg_push), .seg_n_o(seg_n), .seg_bits_o(seg_bits), .evt_o(evt)
  );

  destuff_byte_pack #(.BYTE_W(BYTE_W), .SEG_W(SEG_W)) i_pack (
    .clk_i, .rst_ni,
    .push_i(seg_push && open), .n_i(seg_n), .bits_i(seg_bits), .clear_i(evt.flag),
    .fire_o(fire), .byte_o, .byte_valid_o, .any_o(any), .partial_o(partial)
  );

  destuff_frame_ctl i_ctl (
    .clk_i, .rst_ni, .evt_i(evt), .fire_i(fire), .any_i(any), .partial_i(partial),
    .open_o(open), .sof_o, .eof_o, .abort_o, .residue_o(residue_err_o)
  );

  p_sof_with_byte_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> byte_valid_o);
  p_residue_at_eof_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    residue_err_o |-> eof_o);
  p_eof_abort_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(eof_o && abort_o));
  p_quiet_after_abort_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !byte_valid_o);
  p_gap_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(bit_valid_i) |-> !(byte_valid_o || eof_o || abort_o));
endmodule

// File: tb/test_destuff_rx.sv
module test_destuff_rx;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bit_in, bit_vld;
  logic [7:0] byte_out;
  logic       byte_vld, sof, eof, abrt, res;

  always #5 clk = ~clk;

  destuff_rx i_destuff_rx (
    .clk_i(clk), .rst_ni(rst_n), .bit_i(bit_in), .bit_valid_i(bit_vld),
    .byte_o(byte_out), .byte_valid_o(byte_vld), .sof_o(sof), .eof_o(eof),
    .abort_o(abrt), .residue_err_o(res)
  );

  int errors = 0, checks = 0, cyc = 0;
  int n_sof = 0, n_eof = 0, n_abort = 0, n_res = 0;
  int gap_pct = 0, tx_ones = 0;
  logic [7:0] rx_q[$];

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (byte_vld) rx_q.push_back(byte_out);
      if (sof)  n_sof++;
      if (eof)  n_eof++;
      if (abrt) n_abort++;
      if (res)  n_res++;
    end
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic b);
    while ($urandom_range(99) < gap_pct) begin
      @(negedge clk); bit_vld = 1'b0; bit_in = 1'($urandom);
    end
    @(negedge clk); bit_vld = 1'b1; bit_in = b;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); bit_vld = 1'b0; end
  endtask

  task automatic tx_flag();
    drive(1'b0);
    repeat (6) drive(1'b1);
    drive(1'b0);
    tx_ones = 0;
  endtask

  task automatic tx_data_bit(input logic b);
    drive(b);
    if (b) begin
      tx_ones++;
      if (tx_ones == 5) begin drive(1'b0); tx_ones = 0; end
    end else tx_ones = 0;
  endtask

  task automatic tx_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) tx_data_bit(v[i]);
  endtask

  function automatic logic [7:0] pick_byte();
    int r = $urandom_range(7);
    if (r < 2) return 8'hFF;
    if (r == 2) return 8'h7E;
    return 8'($urandom);
  endfunction

  // payload, residue bits (pattern 1,0,1,...) and closing flag; opening flag already sent
  task automatic run_frame(input logic [7:0] pay[$], input int extra);
    int s0 = n_sof, e0 = n_eof, a0 = n_abort, r0 = n_res;
    bit has_data = (pay.size() > 0) || (extra > 0);
    int bad = -1;
    rx_q.delete();
    foreach (pay[i]) tx_byte(pay[i]);
    for (int i = 0; i < extra; i++) tx_data_bit(1'((i + 1) % 2));
    tx_flag();
    idle(3);
    chk(rx_q.size() == pay.size(), "R5 byte count", rx_q.size(), pay.size());
    foreach (pay[i]) if (i < rx_q.size() && rx_q[i] != pay[i] && bad < 0) bad = i;
    chk(bad < 0, "R3/R5 payload byte", (bad < 0) ? 0 : rx_q[bad], (bad < 0) ? 0 : pay[bad]);
    chk(n_eof - e0 == int'(has_data), has_data ? "R6 eof" : "R7 no eof", n_eof - e0, int'(has_data));
    chk(n_sof - s0 == int'(pay.size() > 0), "R9 sof", n_sof - s0, int'(pay.size() > 0));
    chk(n_res - r0 == int'(extra % 8 != 0), "R8 residue", n_res - r0, int'(extra % 8 != 0));
    chk(n_abort == a0, "R4 no abort", n_abort - a0, 0);
  endtask

  initial begin
    logic [7:0] p[$];
    int a0, e0;
    void'($urandom(32'h1d5e_ed01));
    rst_n = 1'b0; bit_vld = 1'b0; bit_in = 1'b0;
    repeat (3) @(negedge clk);
    chk(byte_out == 8'h00, "R1 byte_o", byte_out, 0);
    chk({byte_vld, sof, eof, abrt, res} == 5'b0, "R1 pulses", {byte_vld, sof, eof, abrt, res}, 0);
    rst_n = 1'b1;
    idle(2);

    // R4: long ones run before any flag gives no abort; R2: stuffed data without flag gives no byte
    repeat (15) drive(1'b1);
    tx_ones = 0;
    repeat (4) tx_byte(pick_byte());
    idle(3);
    chk(n_abort == 0, "R4 abort while closed", n_abort, 0);
    chk(rx_q.size() == 0, "R2 bytes before flag", rx_q.size(), 0);

    tx_flag();
    p = '{8'hA5, 8'h3C, 8'h01};                 run_frame(p, 0);
    p = '{8'hFF, 8'h7E, 8'hFC, 8'h1F, 8'h3F};  run_frame(p, 0);  // R3 stuffing
    tx_flag();                                    // R7 repeated flag
    p = {};                                       run_frame(p, 0);
    p = '{8'h55, 8'hAA};                        run_frame(p, 3);  // R8
    p = {};                                       run_frame(p, 5);  // R8 residue only

    // R4 abort mid frame
    a0 = n_abort; e0 = n_eof; rx_q.delete();
    tx_byte(8'h12); tx_byte(8'h34);
    repeat (8) drive(1'b1);
    idle(3);
    chk(n_abort - a0 == 1, "R4 abort pulse", n_abort - a0, 1);
    chk(n_eof == e0, "R4 no eof on abort", n_eof - e0, 0);
    rx_q.delete(); tx_ones = 0;
    repeat (3) tx_byte(pick_byte());
    idle(3);
    chk(rx_q.size() == 0, "R4 no bytes after abort", rx_q.size(), 0);
    tx_flag();
    p = '{8'hC3};                                run_frame(p, 0);

    // R10 strobe gaps with random line values
    gap_pct = 40;
    p = '{8'h81, 8'hFF, 8'h00, 8'h7F};          run_frame(p, 0);

    // random frames, shared and repeated flags
    gap_pct = 20;
    for (int f = 0; f < 40; f++) begin
      int len = $urandom_range(8);
      int ex  = ($urandom_range(1) == 0) ? 0 : $urandom_range(7);
      p = {};
      for (int k = 0; k < len; k++) p.push_back(pick_byte());
      if ($urandom_range(9) == 0) tx_flag();
      run_frame(p, ex);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule